// File: doc/BRIEF.md
# Three-Word Unlock Key Gate

This block guards access to a protected information region. Software opens the region by writing three fixed 32-bit key words, one after another, to a single write-only register on the register bus. When the last word of the sequence is accepted, the gate raises a registered access-enable output. The memory access path uses this output to allow reads and writes of the protected region.

While the gate is open, any write to the key register closes it again. The value of that write does not matter. A word that does not match the expected key sends the sequence back to its start. However, if that wrong word is equal to the first key, it is taken as the first step of a new attempt. Reads of the register always return zero, so the progress of the sequence is never visible on the bus.

Top module: `info_unlock_gate`

## Requirements
- R1: After reset, access_en is 0 and the key sequence stands at its start.
- R2: Only a write with wr_en high and wr_addr equal to the key register offset (0x40 by default) is taken as a key write. Writes to any other address change neither access_en nor the sequence progress.
- R3: Three key writes of 0x3A7F5CA3, 0xA1E34F20 and 0x9608B2C1, in that order, set access_en high. It rises in the cycle after the clock edge that samples the third write.
- R4: A key word that does not match the expected one returns the sequence to its start. After that, a complete three-word sequence is needed before access is granted.
- R5: A mismatching word that equals 0x3A7F5CA3 counts as the first step of a new sequence.
- R6: While access_en is high, a key write of any value clears access_en in the next cycle. That write leaves the sequence at its start, even when its value is 0x3A7F5CA3.
- R7: rd_data is always zero.
- R8: Idle cycles, and writes to other addresses between key writes, do not disturb the progress of the sequence.
- R9: A key word written out of order, for example the second or third key first, does not advance the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register bus write strobe |
| wr_addr | input | ADDR_W | Register bus write address |
| wr_data | input | DATA_W | Register bus write data |
| rd_data | output | DATA_W | Read data of the key register, always zero |
| access_en | output | 1 | Access enable for the protected region |

## Verification
The bench builds the gate with its default parameters: 8-bit addresses, 32-bit data, the key register at 0x40, and the three default key words. Because of this, the random stimulus can be weighted toward the exact key values and the key register address. The weighting makes complete sequences, broken sequences, restarts on the first key and relocking writes frequent, rather than vanishingly rare.

// File: rtl/info_unlock_gate.sv
module info_unlock_gate #(
  parameter int                ADDR_W  = 8,
  parameter int                DATA_W  = 32,
  parameter logic [ADDR_W-1:0] KEY_OFS = 8'h40,
  parameter logic [DATA_W-1:0] KEY_A   = 32'h3A7F5CA3,
  parameter logic [DATA_W-1:0] KEY_B   = 32'hA1E34F20,
  parameter logic [DATA_W-1:0] KEY_C   = 32'h9608B2C1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              access_en
);

  logic [1:0] step_q, step_d;
  logic       open_q, open_d;

  wire hit     = wr_en && (wr_addr == KEY_OFS);
  wire is_a    = (wr_data == KEY_A);
  wire restart = is_a;

  always_comb begin
    step_d = step_q;
    open_d = open_q;
    if (hit) begin
      if (open_q) begin
        open_d = 1'b0;
        step_d = 2'd0;
      end else begin
        case (step_q)
          2'd0: step_d = is_a ? 2'd1 : 2'd0;
          2'd1: step_d = (wr_data == KEY_B) ? 2'd2 : (restart ? 2'd1 : 2'd0);
          2'd2: begin
            if (wr_data == KEY_C) begin
              open_d = 1'b1;
              step_d = 2'd0;
            end else begin
              step_d = restart ? 2'd1 : 2'd0;
            end
          end
          default: step_d = 2'd0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= 2'd0;
      open_q <= 1'b0;
    end else begin
      step_q <= step_d;
      open_q <= open_d;
    end
  end

  assign access_en = open_q;
  assign rd_data   = '0;

  assert_step_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_q != 2'd3);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> ($stable(step_q) && $stable(access_en)));

  assert_third_key_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !access_en && step_q == 2'd2 && wr_data == KEY_C) |=> access_en);

  assert_write_relocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && access_en) |=> (!access_en && step_q == 2'd0));

  assert_open_needs_key_c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_en) |-> $past(hit && wr_data == KEY_C));

  assert_first_key_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !access_en && wr_data == KEY_A) |=> (step_q == 2'd1));

  assert_open_step_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    access_en |-> step_q == 2'd0);

endmodule

// File: tb/info_unlock_gate_test.sv
module info_unlock_gate_test;
  localparam logic [7:0]  OFS = 8'h40;
  localparam logic [31:0] KA  = 32'h3A7F5CA3;
  localparam logic [31:0] KB  = 32'hA1E34F20;
  localparam logic [31:0] KC  = 32'h9608B2C1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        access_en;

  int checks = 0;
  int errors = 0;
  int m_step = 0;
  bit m_open = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  info_unlock_gate uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .access_en(access_en)
  );

  function automatic int next_step(int s, bit o, bit w, logic [7:0] a, logic [31:0] d);
    if (!(w && a == OFS)) return s;
    if (o) return 0;
    if (s == 1 && d == KB) return 2;
    if (s == 2 && d == KC) return 0;
    return (d == KA) ? 1 : 0;
  endfunction

  function automatic bit next_open(int s, bit o, bit w, logic [7:0] a, logic [31:0] d);
    if (!(w && a == OFS)) return o;
    if (o) return 1'b0;
    return (s == 2 && d == KC);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle(string req, bit w, logic [7:0] a, logic [31:0] d);
    int ns;
    bit no;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d;
    ns = next_step(m_step, m_open, w, a, d);
    no = next_open(m_step, m_open, w, a, d);
    @(negedge clk);
    wr_en = 1'b0;
    m_step = ns; m_open = no;
    check(req, {31'd0, access_en}, {31'd0, m_open});
    check("R7", rd_data, 32'd0);
  endtask

  task automatic key(string req, logic [31:0] d);
    cycle(req, 1'b1, OFS, d);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", {31'd0, access_en}, 32'd0);
    check("R7", rd_data, 32'd0);
    rst_n = 1'b1;
    cycle("R1", 1'b0, OFS, 32'd0);

    key("R3", KA); key("R3", KB);
    check("R3", {31'd0, access_en}, 32'd0);
    key("R3", KC);
    check("R3", {31'd0, access_en}, 32'd1);
    key("R6", KA);
    check("R6", {31'd0, access_en}, 32'd0);
    key("R6", KB); key("R6", KC);
    check("R6", {31'd0, access_en}, 32'd0);

    key("R4", KA); key("R4", 32'h12345678); key("R4", KB); key("R4", KC);
    check("R4", {31'd0, access_en}, 32'd0);
    key("R4", KA); key("R4", KB); key("R4", 32'h0); key("R4", KC);
    check("R4", {31'd0, access_en}, 32'd0);

    key("R5", KA); key("R5", KA); key("R5", KB); key("R5", KC);
    check("R5", {31'd0, access_en}, 32'd1);
    key("R6", 32'hFFFFFFFF);
    check("R6", {31'd0, access_en}, 32'd0);
    key("R5", KA); key("R5", KB); key("R5", KA); key("R5", KB); key("R5", KC);
    check("R5", {31'd0, access_en}, 32'd1);
    key("R6", 32'h0);

    key("R9", KB); key("R9", KC);
    check("R9", {31'd0, access_en}, 32'd0);
    key("R9", KC); key("R9", KB); key("R9", KC);
    check("R9", {31'd0, access_en}, 32'd0);

    key("R8", KA);
    cycle("R8", 1'b0, OFS, 32'hDEADBEEF);
    cycle("R2", 1'b1, 8'h44, 32'h0);
    key("R8", KB);
    cycle("R2", 1'b1, 8'h3C, KA);
    cycle("R8", 1'b0, 8'h00, 32'h0);
    key("R8", KC);
    check("R8", {31'd0, access_en}, 32'd1);
    cycle("R2", 1'b1, 8'h00, 32'h1);
    check("R2", {31'd0, access_en}, 32'd1);
    key("R6", KC);

    cycle("R2", 1'b1, 8'h41, KA); cycle("R2", 1'b1, 8'h48, KB); cycle("R2", 1'b1, 8'hC0, KC);
    check("R2", {31'd0, access_en}, 32'd0);

    for (int i = 0; i < 4000; i++) begin
      int  r = int'($urandom_range(0, 9));
      bit  w = ($urandom_range(0, 4) != 0);
      logic [7:0]  a = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(0, 255)) : OFS;
      logic [31:0] d;
      if (r < 3) d = KA;
      else if (r < 5) d = KB;
      else if (r < 7) d = KC;
      else d = $urandom;
      if (m_step == 1 && $urandom_range(0, 1) == 1) d = KB;
      if (m_step == 2 && $urandom_range(0, 1) == 1) d = KC;
      cycle("R3/R4/R5/R6 random", w, a, d);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule